// File: doc/BRIEF.md
# Status-Enable Event Interrupt Router

This block gathers a bank of hardware event lines into a single interrupt request. Each event has its own cell. The cell holds a sticky status flag, which an event sets, and a separate enable flag, which software programs. A status flag stays set after its event goes away. Software clears it only by writing a 1 to its bit position. The enable flag does not take part in setting or clearing the status flag. It only decides whether a pending status flag adds to the interrupt request.

The request is the OR of every cell whose status and enable flags are both 1. A routing mode bit sends that request to one of two outputs. With the mode bit clear, it drives the system-management interrupt output. With the mode bit set, it drives the OS-visible interrupt output. Both outputs are level signals: each stays high while any enabled status flag is still set, so several sources can share one line.

A separate group of OS-transparent inputs always drives the system-management output, whatever the mode. A synchronous host port with byte addressing reads and writes the status register, the enable register and the mode bit. A parameter mask marks which event bits exist. The event inputs are assumed to be synchronous to the clock already.

Top module: `evt_irq_router`

## Requirements
- R1: After synchronous reset, all status bits, all enable bits and the mode bit are 0. Both interrupt outputs are low.
- R2: An event input that is high at a clock edge sets its status bit at that edge. The bit stays set after the input returns low.
- R3: A write to byte offset 0 clears each status bit where the write data holds a 1. Status bits where the write data holds a 0 keep their value.
- R4: If an event input is high in the same cycle as a clearing write to its bit, the status bit stays 1.
- R5: An enable bit has no effect on setting or holding its status bit. With the enable bit at 0, an event still sets the status bit, and a read at offset 0 returns it.
- R6: The interrupt request is the OR over all bits of (status AND enable). The selected output goes high one clock edge after the status and enable registers make the request true. It stays high while any enabled status bit remains set, and it goes low one edge after the last one is cleared or disabled.
- R7: The mode bit is bit 0 at byte offset 4. With mode 0 the request drives smi_o and sci_o stays low. With mode 1 the request drives sci_o and the request does not drive smi_o.
- R8: Any high always-SMI input drives smi_o high one edge later, in either mode, and never drives sci_o.
- R9: Bits that are clear in the implemented-bit mask (default 0xBFFB, so bits 2 and 14 are absent) read as 0 in the status and enable registers. Writes to those bits have no effect, and events on them set nothing and raise no interrupt.
- R10: The enable register sits at byte offset 2. A read returns data on rdata after the edge that samples rd_en, and that data reflects register state from before that edge. Reads of any other offset return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 16 | Event inputs, one per cell, active high |
| smi_src_i | input | 2 | OS-transparent sources, always routed to smi_o |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| addr | input | 8 | Host byte address |
| wdata | input | 16 | Host write data |
| rdata | output | 16 | Registered host read data |
| smi_o | output | 1 | System-management interrupt, level, registered |
| sci_o | output | 1 | OS-visible shareable interrupt, level, registered |

## Verification
The bench drives event patterns and compares the results against expected values. Single-bit pulses with the enable bit off show that status latching does not depend on enable. Two pending enabled bits, cleared one at a time, show that the output is a level OR and not a single edge. A pulse that coincides with its own clearing write separates set-wins priority from clear-wins. Toggling the mode bit with the same pending events shows that only the output changes, not the status. Pulses on every bit, including the unimplemented ones, together with all-ones writes, separate the implemented cells from the masked positions.

// File: rtl/evt_rtr_pkg.sv
package evt_rtr_pkg;

  localparam int unsigned OFS_STATUS = 0;
  localparam int unsigned OFS_ENABLE = 2;
  localparam int unsigned OFS_MODE   = 4;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_STATUS,
    SEL_ENABLE,
    SEL_MODE
  } reg_sel_e;

  function automatic reg_sel_e decode_ofs(input int unsigned ofs);
    if (ofs == OFS_STATUS)      return SEL_STATUS;
    else if (ofs == OFS_ENABLE) return SEL_ENABLE;
    else if (ofs == OFS_MODE)   return SEL_MODE;
    else                        return SEL_NONE;
  endfunction

endpackage

// File: rtl/evt_cell_bank.sv
module evt_cell_bank #(
  parameter int unsigned         N_EVT    = 16,
  parameter logic [N_EVT-1:0]    IMPL_MSK = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_EVT-1:0] evt_i,
  input  logic [N_EVT-1:0] clr_i,
  input  logic             en_wr_i,
  input  logic [N_EVT-1:0] en_data_i,
  output logic [N_EVT-1:0] status_o,
  output logic [N_EVT-1:0] enable_o,
  output logic [N_EVT-1:0] pend_o
);

  for (genvar i = 0; i < N_EVT; i++) begin : g_cell
    logic st_q;
    logic en_q;

    // set has priority over a same-cycle clear
    always_ff @(posedge clk) begin
      if (rst) begin
        st_q <= 1'b0;
        en_q <= 1'b0;
      end else begin
        st_q <= IMPL_MSK[i] & (evt_i[i] | (st_q & ~clr_i[i]));
        if (en_wr_i) en_q <= IMPL_MSK[i] & en_data_i[i];
      end
    end

    assign status_o[i] = st_q;
    assign enable_o[i] = en_q;
    assign pend_o[i]   = st_q & en_q;
  end

endmodule

// File: rtl/evt_host_regs.sv
module evt_host_regs
  import evt_rtr_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned N_EVT  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [N_EVT-1:0]  status_i,
  input  logic [N_EVT-1:0]  enable_i,
  output logic [N_EVT-1:0]  clr_o,
  output logic              en_wr_o,
  output logic [N_EVT-1:0]  en_data_o,
  output logic              mode_o,
  output logic [DATA_W-1:0] rdata
);

  reg_sel_e    sel;
  logic        mode_q;
  logic [DATA_W-1:0] rd_mux;

  assign sel       = decode_ofs(int'(addr));
  assign clr_o     = (wr_en && sel == SEL_STATUS) ? wdata[N_EVT-1:0] : '0;
  assign en_wr_o   = wr_en && sel == SEL_ENABLE;
  assign en_data_o = wdata[N_EVT-1:0];
  assign mode_o    = mode_q;

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_STATUS: rd_mux = DATA_W'(status_i);
      SEL_ENABLE: rd_mux = DATA_W'(enable_i);
      SEL_MODE:   rd_mux = DATA_W'(mode_q);
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= 1'b0;
      rdata  <= '0;
    end else begin
      if (wr_en && sel == SEL_MODE) mode_q <= wdata[0];
      if (rd_en) rdata <= rd_mux;
    end
  end

endmodule

// File: rtl/evt_irq_route.sv
module evt_irq_route #(
  parameter int unsigned N_EVT = 16,
  parameter int unsigned N_SMI = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_EVT-1:0] pend_i,
  input  logic             mode_i,
  input  logic [N_SMI-1:0] smi_src_i,
  output logic             smi_o,
  output logic             sci_o
);

  logic req;
  assign req = |pend_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      smi_o <= 1'b0;
      sci_o <= 1'b0;
    end else begin
      smi_o <= (req & ~mode_i) | (|smi_src_i);
      sci_o <= req & mode_i;
    end
  end

endmodule

// File: rtl/evt_irq_router.sv
module evt_irq_router #(
  parameter int unsigned      ADDR_W   = 8,
  parameter int unsigned      DATA_W   = 16,
  parameter int unsigned      N_EVT    = 16,
  parameter int unsigned      N_SMI    = 2,
  parameter logic [N_EVT-1:0] IMPL_MSK = 16'hBFFB
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_EVT-1:0]  evt_i,
  input  logic [N_SMI-1:0]  smi_src_i,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              smi_o,
  output logic              sci_o
);

  logic [N_EVT-1:0] sts, ena, pend, clr, en_data;
  logic             en_wr, mode;

  evt_host_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_EVT(N_EVT)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .status_i(sts), .enable_i(ena), .clr_o(clr),
    .en_wr_o(en_wr), .en_data_o(en_data), .mode_o(mode), .rdata(rdata)
  );

  evt_cell_bank #(.N_EVT(N_EVT), .IMPL_MSK(IMPL_MSK)) u_bank (
    .clk(clk), .rst(rst), .evt_i(evt_i), .clr_i(clr), .en_wr_i(en_wr),
    .en_data_i(en_data), .status_o(sts), .enable_o(ena), .pend_o(pend)
  );

  evt_irq_route #(.N_EVT(N_EVT), .N_SMI(N_SMI)) u_route (
    .clk(clk), .rst(rst), .pend_i(pend), .mode_i(mode),
    .smi_src_i(smi_src_i), .smi_o(smi_o), .sci_o(sci_o)
  );

endmodule

// File: rtl/evt_irq_router_chk.sv
module evt_irq_router_chk #(
  parameter int unsigned      ADDR_W   = 8,
  parameter int unsigned      N_EVT    = 16,
  parameter int unsigned      N_SMI    = 2,
  parameter logic [N_EVT-1:0] IMPL_MSK = 16'hBFFB
) (
  input logic              clk,
  input logic              rst,
  input logic [N_EVT-1:0]  evt_i,
  input logic [N_SMI-1:0]  smi_src_i,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [N_EVT-1:0]  sts,
  input logic [N_EVT-1:0]  ena,
  input logic              mode,
  input logic              smi_o,
  input logic              sci_o
);

  logic sts_wr;
  assign sts_wr = wr_en && (addr == ADDR_W'(0));

  // R3: without a status write, no set bit is lost
  a_r3_sticky: assert property (@(posedge clk) disable iff (rst)
    !sts_wr |=> ((sts & $past(sts)) == $past(sts)));

  // R2, R4: an implemented event always leaves its bit set, even against a clear
  a_r4_set_wins: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(evt_i) & IMPL_MSK & ~sts) == '0));

  // R6, R7: sci_o follows the pending request one edge later in mode 1
  a_r7_sci_follows: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (sci_o == ($past(mode) && (|($past(sts & ena))))));

  // R7: in mode 0 the OS-visible output stays low
  a_r7_sci_quiet: assert property (@(posedge clk) disable iff (rst)
    !mode |=> !sci_o);

  // R8: an always-SMI input raises smi_o in either mode
  a_r8_smi_src: assert property (@(posedge clk) disable iff (rst)
    (|smi_src_i) |=> smi_o);

endmodule

bind evt_irq_router evt_irq_router_chk #(
  .ADDR_W(ADDR_W), .N_EVT(N_EVT), .N_SMI(N_SMI), .IMPL_MSK(IMPL_MSK)
) u_chk (
  .clk(clk), .rst(rst), .evt_i(evt_i), .smi_src_i(smi_src_i), .wr_en(wr_en),
  .addr(addr), .sts(sts), .ena(ena), .mode(mode), .smi_o(smi_o), .sci_o(sci_o)
);

// File: tb/evt_irq_router_test.sv
module evt_irq_router_test;

  localparam logic [15:0] MSK = 16'hBFFB;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] evt_i = '0;
  logic [1:0]  smi_src_i = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        smi_o, sci_o;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  evt_irq_router uut (
    .clk(clk), .rst(rst), .evt_i(evt_i), .smi_src_i(smi_src_i),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .smi_o(smi_o), .sci_o(sci_o)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic host_wr(input logic [7:0] a, input logic [15:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic host_rd(input logic [7:0] a, output logic [15:0] d);
    addr = a; rd_en = 1'b1;
    tick();
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic pulse(input logic [15:0] e);
    evt_i = e;
    tick();
    evt_i = '0;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    check("R1 smi_o", {15'b0, smi_o}, 16'h0);
    check("R1 sci_o", {15'b0, sci_o}, 16'h0);
    host_rd(8'd0, d); check("R1 status", d, 16'h0);
    host_rd(8'd2, d); check("R1 enable", d, 16'h0);
    host_rd(8'd4, d); check("R1 mode", d, 16'h0);
  endtask

  task automatic t_latch();
    logic [15:0] d;
    pulse(16'h0008);
    tick();
    host_rd(8'd0, d); check("R2 R5 status latched with enable off", d, 16'h0008);
    check("R6 no request when disabled", {15'b0, smi_o}, 16'h0);
  endtask

  task automatic t_w1c();
    logic [15:0] d;
    host_wr(8'd0, 16'h0000);
    host_rd(8'd0, d); check("R3 zero write keeps bit", d, 16'h0008);
    host_wr(8'd0, 16'h0008);
    host_rd(8'd0, d); check("R3 one write clears bit", d, 16'h0000);
  endtask

  task automatic t_set_wins();
    logic [15:0] d;
    evt_i = 16'h0020;
    host_wr(8'd0, 16'h0020);
    evt_i = '0;
    host_rd(8'd0, d); check("R4 set beats clear", d, 16'h0020);
    host_wr(8'd0, 16'h0020);
    host_rd(8'd0, d); check("R4 later clear works", d, 16'h0000);
  endtask

  task automatic t_route();
    logic [15:0] d;
    host_wr(8'd2, 16'h0022);
    pulse(16'h0022);
    tick();
    check("R7 mode0 smi_o", {15'b0, smi_o}, 16'h1);
    check("R7 mode0 sci_o", {15'b0, sci_o}, 16'h0);
    host_wr(8'd4, 16'h0001);
    tick();
    check("R7 mode1 sci_o", {15'b0, sci_o}, 16'h1);
    check("R7 mode1 smi_o", {15'b0, smi_o}, 16'h0);
    host_rd(8'd4, d); check("R7 mode readback", d, 16'h0001);
    host_wr(8'd0, 16'h0002);
    tick();
    check("R6 level held with one pending", {15'b0, sci_o}, 16'h1);
    host_wr(8'd0, 16'h0020);
    tick();
    check("R6 drops after last clear", {15'b0, sci_o}, 16'h0);
  endtask

  task automatic t_enable_gate();
    host_wr(8'd2, 16'h0000);
    pulse(16'h0080);
    tick();
    check("R5 pending but disabled", {15'b0, sci_o}, 16'h0);
    host_wr(8'd2, 16'h0080);
    check("R6 one edge latency", {15'b0, sci_o}, 16'h0);
    tick();
    check("R6 enable raises sci_o", {15'b0, sci_o}, 16'h1);
    host_wr(8'd2, 16'h0000);
    tick();
    check("R6 disable drops sci_o", {15'b0, sci_o}, 16'h0);
    host_wr(8'd0, 16'hFFFF);
  endtask

  task automatic t_smi_src();
    smi_src_i = 2'b10;
    tick();
    check("R8 smi_o in mode1", {15'b0, smi_o}, 16'h1);
    check("R8 no sci_o", {15'b0, sci_o}, 16'h0);
    smi_src_i = 2'b00;
    tick();
    check("R8 smi_o released", {15'b0, smi_o}, 16'h0);
  endtask

  task automatic t_reserved();
    logic [15:0] d;
    host_wr(8'd2, 16'hFFFF);
    host_rd(8'd2, d); check("R9 enable mask", d, MSK);
    pulse(16'h4004);
    tick();
    host_rd(8'd0, d); check("R9 absent bits never set", d, 16'h0000);
    check("R9 no interrupt", {15'b0, sci_o}, 16'h0);
    pulse(16'hFFFF);
    host_rd(8'd0, d); check("R9 status mask", d, MSK);
    host_wr(8'd0, 16'hFFFF);
    host_rd(8'd0, d); check("R9 all cleared", d, 16'h0000);
  endtask

  task automatic t_bad_addr();
    logic [15:0] d;
    host_rd(8'd6, d); check("R10 unmapped reads zero", d, 16'h0000);
    host_rd(8'd2, d); check("R10 enable offset", d, MSK);
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    checks++;
    $display("FAIL R1 watchdog expired: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_latch();
    t_w1c();
    t_set_wins();
    t_route();
    t_enable_gate();
    t_smi_src();
    t_reserved();
    t_bad_addr();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule